// File: doc/BRIEF.md
# Bus master latency timer

This block holds the latency budget of a PCI bus master and turns it into a termination request. Software programs an 8-bit value, counted in bus clocks, into a register that it can also read back. When the master begins a transaction by driving FRAME, the value is copied into a down-counter. The counter then steps down once per clock for as long as FRAME stays asserted.

Running out of count does not end the transaction by itself. The block asks for termination only once the count has expired and the arbiter has also taken the grant away. If the master releases FRAME before the count runs out, the count is thrown away and nothing is requested. The termination request stays high until FRAME is released. The rest of the master state machine reads this request and finishes the transaction.

Both `frame_own` and `bus_gnt` are active-high views of the bus signals. Any inversion of the active-low pins is done outside this block.

Top module: `mst_lat_timer`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cfg_rdata` reads 8'h00 and `term_req` is 0.
- R2: A write (`cfg_we`=1) stores `cfg_wdata` at the clock edge. `cfg_rdata` shows the stored value from that edge onward.
- R3: A start edge is a clock edge at which `frame_own` is 1 and was 0 at the previous edge. At a start edge the count is loaded from the register value held before that edge. After that it decrements once per clock edge while `frame_own` stays 1, and it stops at zero.
- R4: With a loaded value L, `term_req` never rises at or before edge L after the start edge. It rises at the first edge k ≥ L+1 after the start edge at which `frame_own` is 1 and `bus_gnt` is 0.
- R5: While `bus_gnt` stays 1, `term_req` stays 0 even after the count has expired.
- R6: If `frame_own` drops before `term_req` rises, nothing is requested. The next start edge reloads the full register value.
- R7: With a loaded value of 8'h00 the count is expired from the start edge. `term_req` can rise at the very next edge.
- R8: Once high, `term_req` stays high while `frame_own` is 1, even if `bus_gnt` returns to 1. It is 0 after the first edge at which `frame_own` is 0.
- R9: A register write during a transaction does not change that transaction's count. It takes effect at the next start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe for the timer register |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current register value for configuration reads |
| frame_own | input | 1 | High while this master drives FRAME asserted |
| bus_gnt | input | 1 | High while the arbiter grants the bus to this master |
| term_req | output | 1 | Request to terminate the current master transaction |

## Verification
The assertions check a set of rules on every cycle. A request never survives a FRAME release. A request only rises after the grant was low and the count had expired. A raised request holds while FRAME holds. A write is visible in the register one edge later. These rules cannot show when the request rises relative to the programmed value, so the bench covers that with its scenarios: exact expiry edges for several values including zero, grant held high past expiry, early release followed by a full reload, and a write landing mid-transaction. A long pseudo-random stretch is compared against a behavioural model on every clock.

// File: rtl/mst_lat_timer.sv
module mst_lat_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_wdata,
  output logic [W-1:0] cfg_rdata,
  input  logic         frame_own,
  input  logic         bus_gnt,
  output logic         term_req
);

  logic [W-1:0] lat_q, cnt_q;
  logic         frame_d, expd_q, term_q;
  logic         start;

  assign start     = frame_own & ~frame_d;
  assign cfg_rdata = lat_q;
  assign term_req  = term_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      cnt_q   <= '0;
      frame_d <= 1'b0;
      expd_q  <= 1'b0;
      term_q  <= 1'b0;
    end else begin
      if (cfg_we) lat_q <= cfg_wdata;
      frame_d <= frame_own;
      if (!frame_own) begin
        cnt_q  <= '0;
        expd_q <= 1'b0;
        term_q <= 1'b0;
      end else if (start) begin
        cnt_q  <= lat_q;
        expd_q <= (lat_q == '0);
      end else begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        expd_q <= expd_q | (cnt_q <= W'(1));
        if (expd_q && !bus_gnt) term_q <= 1'b1;
      end
    end
  end

  // R8: no request survives a FRAME release
  a_r8_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_own |=> !term_req);

  // R8: a raised request holds while FRAME holds
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (term_req && frame_own) |=> term_req);

  // R5: a request only rises when grant was removed
  a_r5_needs_gnt_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_req) |-> $past(!bus_gnt));

  // R4: a request only rises after expiry
  a_r4_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(term_req) |-> $past(expd_q));

  // R2: written value is visible after the edge
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == $past(cfg_wdata)));

  // R3: the count is stable at zero once expired
  a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_own && frame_d && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: tb/mst_lat_timer_tb.sv
module mst_lat_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic       frame_own = 1'b0;
  logic       bus_gnt = 1'b1;
  logic       term_req;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string req = "R1";

  // behavioural model
  logic [7:0] m_lat = 8'h00;
  bit   m_active = 0;
  bit   m_term = 0;
  int   m_load = 0;
  int   m_k = 0;

  always #2 clk = ~clk;

  mst_lat_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_own(frame_own), .bus_gnt(bus_gnt),
    .term_req(term_req)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lat = 8'h00; m_active = 0; m_term = 0; m_k = 0; m_load = 0;
    end else begin
      if (!frame_own) begin
        m_active = 0; m_term = 0;
      end else if (!m_active) begin
        m_active = 1; m_load = int'(m_lat); m_k = 0;
      end else begin
        if (m_k >= m_load && !bus_gnt) m_term = 1;
        if (m_k < 1000) m_k++;
      end
      if (cfg_we) m_lat = cfg_wdata;
    end
  end

  task automatic compare();
    checks++;
    if (term_req !== m_term) begin
      errors++;
      $display("FAIL %s term_req actual=%b expected=%b at cycle %0d", req, term_req, m_term, cycles);
    end
    checks++;
    if (cfg_rdata !== m_lat) begin
      errors++;
      $display("FAIL %s cfg_rdata actual=%h expected=%h at cycle %0d", req, cfg_rdata, m_lat, cycles);
    end
  endtask

  task automatic cyc(int n, bit we, logic [7:0] wd, bit fr, bit g);
    for (int i = 0; i < n; i++) begin
      cfg_we = we; cfg_wdata = wd; frame_own = fr; bus_gnt = g;
      @(posedge clk);
      @(negedge clk);
      cycles++;
      compare();
    end
  endtask

  task automatic expect_term(bit exp, string r);
    checks++;
    if (term_req !== exp) begin
      errors++;
      $display("FAIL %s explicit term_req actual=%b expected=%b", r, term_req, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #50000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // R1 during reset
    repeat (3) @(negedge clk);
    req = "R1"; compare();
    rst_n = 1'b1;
    cyc(2, 0, 8'h00, 0, 1);
    // R2 write and readback
    req = "R2";
    cyc(1, 1, 8'h5A, 0, 1);
    cyc(1, 0, 8'h00, 0, 1);
    cyc(1, 1, 8'h03, 0, 1);
    // R3 R4 L=3, grant low throughout: rises at edge 4
    req = "R4";
    cyc(4, 0, 8'h00, 1, 0);
    expect_term(0, "R4");
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(1, "R4");
    cyc(3, 0, 8'h00, 1, 0);
    req = "R8"; cyc(2, 0, 8'h00, 0, 1);
    expect_term(0, "R8");
    // R7 value zero
    req = "R7";
    cyc(1, 1, 8'h00, 0, 1);
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(0, "R7");
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(1, "R7");
    // R8 grant returns, request holds
    req = "R8";
    cyc(3, 0, 8'h00, 1, 1);
    expect_term(1, "R8");
    cyc(1, 0, 8'h00, 0, 1);
    expect_term(0, "R8");
    // R5 grant held high past expiry
    req = "R5";
    cyc(1, 1, 8'h02, 0, 1);
    cyc(8, 0, 8'h00, 1, 1);
    expect_term(0, "R5");
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(1, "R5");
    cyc(1, 0, 8'h00, 0, 1);
    // R6 early release then full reload
    req = "R6";
    cyc(1, 1, 8'h05, 0, 0);
    cyc(4, 0, 8'h00, 1, 0);
    cyc(1, 0, 8'h00, 0, 0);
    expect_term(0, "R6");
    cyc(6, 0, 8'h00, 1, 0);
    expect_term(0, "R6");
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(1, "R6");
    cyc(1, 0, 8'h00, 0, 1);
    // R9 write during a transaction
    req = "R9";
    cyc(1, 1, 8'h04, 0, 1);
    cyc(1, 0, 8'h00, 1, 0);
    cyc(1, 1, 8'h00, 1, 0);
    cyc(3, 0, 8'h00, 1, 0);
    expect_term(0, "R9");
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(1, "R9");
    cyc(1, 0, 8'h00, 0, 1);
    cyc(1, 0, 8'h00, 1, 0);
    cyc(1, 0, 8'h00, 1, 0);
    expect_term(1, "R9");
    cyc(1, 0, 8'h00, 0, 1);
    // R3 pseudo-random traffic against the model
    req = "R3";
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(1, (lfsr[3:0] == 4'h0), {5'b0, lfsr[9:7]}, (lfsr[6:4] != 3'b000), lfsr[11] | lfsr[12]);
    end
    finish_run();
  end
endmodule